// File: doc/BRIEF.md
# DShot Frame Transmitter

This block serialises a motor-control word for electronic speed controllers. A producer offers an 11-bit value and a telemetry-request flag through a valid/ready handshake. At acceptance the block appends a 4-bit nibble-XOR checksum to form a 16-bit frame. It then drives one serial line, most significant bit first. Every bit occupies a fixed number of clock cycles, and a bit's value is carried by how long the line stays in its active level within that period: about one third of the period for a zero, about two thirds for a one.

Four line rates are selectable, nominally 150, 300, 600 and 1200 kbit/s. Each rate has its own cycle-count parameter, so one netlist fits any system clock. A bidirectional flag turns the line polarity upside down, so the line idles high and bits start with a falling edge, and it complements the checksum. After the last bit the line is held idle for three bit periods, and only then is the next request taken. Command values (below 48) and throttle values are framed the same way.

Top module: `dshot_tx`

## Requirements
- R1: The frame is sent most significant bit first in this order: req_value_i[10:0], then req_telem_i, then the 4-bit checksum. That makes 16 bits.
- R2: With bidir_i low at acceptance, the checksum is c = (p ^ (p >> 4) ^ (p >> 8)) & 4'hF, where p = {req_value_i, req_telem_i} is 12 bits wide.
- R3: With bidir_i high at acceptance, the checksum is the bitwise complement of the R2 value.
- R4: Let P be the selected period count. A zero bit keeps the line active for (P+1)/3 cycles and a one bit for (2P+1)/3 cycles, integer division. The first bit becomes active in the second cycle after the accepting clock edge.
- R5: rate_sel_i picks the period count: 0 selects CYC_R150, 1 selects CYC_R300, 2 selects CYC_R600 and 3 selects CYC_R1200. Successive bits start exactly P cycles apart.
- R6: With bidir_i low the line idles low and the active level is high. With bidir_i high the line idles high and the active level is low. While no frame is in progress, the idle level follows bidir_i within two cycles.
- R7: req_ready_o drops, and busy_o rises, on the accepting edge. Both stay that way for 19·P cycles, which is 16 bit periods plus a 3-period idle gap. A request held valid during that time is accepted 19·P+1 cycles after the previous one.
- R8: The rate and polarity are captured at acceptance. Changing rate_sel_i or bidir_i during a frame does not alter that frame.
- R9: After reset, req_ready_o is 1, busy_o is 0 and line_o is 0.
- R10: Every value from 0 to 2047 is framed identically, whether it is a command (0 to 47) or a throttle value (48 and up).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block can accept a request |
| req_value_i | input | 11 | Command or throttle value |
| req_telem_i | input | 1 | Telemetry request flag |
| rate_sel_i | input | 2 | Line-rate code (see R5) |
| bidir_i | input | 1 | Inverted polarity and complemented checksum |
| line_o | output | 1 | Serial output line |
| busy_o | output | 1 | Frame or idle gap in progress |

## Verification
The line is decoded from pulse widths and start spacing alone, and each received frame is compared against a frame the bench builds from the requested value.

The values include 0, 47, 48, 2047 and alternating bit patterns. These separate the command and throttle ranges and catch bit-order or field-position mistakes.

Every rate is used, in both polarities. This separates a wrong period table from a wrong duty split, and a missing checksum complement from a missing line inversion.

Back-to-back held requests pin down the exact gap length. A frame whose rate and polarity inputs are changed mid-transmission shows whether the configuration is really captured at acceptance.

// File: rtl/dshot_tx_pkg.sv
package dshot_tx_pkg;

    localparam int VALUE_W  = 11;
    localparam int CRC_W    = 4;
    localparam int FRAME_W  = VALUE_W + 1 + CRC_W;
    localparam int IDX_W    = $clog2(FRAME_W);
    localparam int RATE_N   = 4;
    localparam int RATE_W   = $clog2(RATE_N);
    localparam int GAP_BITS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dshot_crc.sv
module dshot_crc #(
    parameter int PAYLOAD_W = 12,
    parameter int SUM_W     = 4
) (
    input  logic [PAYLOAD_W-1:0] payload_i,
    input  logic                 invert_i,
    output logic [SUM_W-1:0]     crc_o
);
    localparam int NIB = PAYLOAD_W / SUM_W;

    logic [SUM_W-1:0] fold [NIB];

    // XOR fold of all nibbles of the payload
    for (genvar g = 0; g < NIB; g++) begin : g_fold
        if (g == 0) begin : g_first
            assign fold[g] = payload_i[SUM_W-1:0];
        end else begin : g_next
            assign fold[g] = fold[g-1] ^ payload_i[g*SUM_W +: SUM_W];
        end
    end

    assign crc_o = fold[NIB-1] ^ {SUM_W{invert_i}};
endmodule

// File: rtl/dshot_rate_lut.sv
module dshot_rate_lut #(
    parameter int unsigned CYC_0 = 1334,
    parameter int unsigned CYC_1 = 666,
    parameter int unsigned CYC_2 = 334,
    parameter int unsigned CYC_3 = 166,
    parameter int          CNT_W = 12
) (
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] t_zero_o,
    output logic [CNT_W-1:0] t_one_o
);
    localparam int unsigned PTAB [4] = '{CYC_0, CYC_1, CYC_2, CYC_3};

    logic [CNT_W-1:0] per_tab  [4];
    logic [CNT_W-1:0] zero_tab [4];
    logic [CNT_W-1:0] one_tab  [4];

    // per-rate counts, rounded to whole cycles
    for (genvar g = 0; g < 4; g++) begin : g_rate
        localparam int unsigned P_G  = PTAB[g];
        localparam int unsigned T0_G = (P_G + 1) / 3;
        localparam int unsigned T1_G = (2 * P_G + 1) / 3;
        assign per_tab[g]  = CNT_W'(P_G);
        assign zero_tab[g] = CNT_W'(T0_G);
        assign one_tab[g]  = CNT_W'(T1_G);
    end

    assign period_o = per_tab[sel_i];
    assign t_zero_o = zero_tab[sel_i];
    assign t_one_o  = one_tab[sel_i];
endmodule

// File: rtl/dshot_bit_shape.sv
module dshot_bit_shape #(
    parameter int CNT_W = 12
) (
    input  logic             sending_i,
    input  logic             bit_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] t_zero_i,
    input  logic [CNT_W-1:0] t_one_i,
    input  logic             invert_i,
    output logic             line_o
);
    logic [CNT_W-1:0] hi_len;
    logic             active;

    assign hi_len = bit_i ? t_one_i : t_zero_i;
    assign active = sending_i && (cnt_i < hi_len);
    assign line_o = active ^ invert_i;
endmodule

// File: rtl/dshot_tx.sv
module dshot_tx
    import dshot_tx_pkg::*;
#(
    parameter int unsigned CYC_R150  = 1334,
    parameter int unsigned CYC_R300  = 666,
    parameter int unsigned CYC_R600  = 334,
    parameter int unsigned CYC_R1200 = 166
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [VALUE_W-1:0] req_value_i,
    input  logic               req_telem_i,
    input  logic [RATE_W-1:0]  rate_sel_i,
    input  logic               bidir_i,
    output logic               line_o,
    output logic               busy_o
);
    localparam int unsigned CYC_MAX = max4(CYC_R150, CYC_R300, CYC_R600, CYC_R1200);
    localparam int          CNT_W   = $clog2(GAP_BITS * CYC_MAX + 1);

    typedef struct packed {
        tx_state_e          state;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   period;
        logic [CNT_W-1:0]   t_zero;
        logic [CNT_W-1:0]   t_one;
        logic               bidir;
        logic               line;
    } regs_t;

    regs_t q, d;

    logic [CNT_W-1:0] sel_period, sel_t0, sel_t1;
    logic [CRC_W-1:0] sum;
    logic             line_nx;
    logic [CNT_W-1:0] per_last, gap_last;

    dshot_rate_lut #(
        .CYC_0 (CYC_R150),
        .CYC_1 (CYC_R300),
        .CYC_2 (CYC_R600),
        .CYC_3 (CYC_R1200),
        .CNT_W (CNT_W)
    ) u_lut (
        .sel_i    (rate_sel_i),
        .period_o (sel_period),
        .t_zero_o (sel_t0),
        .t_one_o  (sel_t1)
    );

    dshot_crc #(
        .PAYLOAD_W (VALUE_W + 1),
        .SUM_W     (CRC_W)
    ) u_crc (
        .payload_i ({req_value_i, req_telem_i}),
        .invert_i  (bidir_i),
        .crc_o     (sum)
    );

    dshot_bit_shape #(
        .CNT_W (CNT_W)
    ) u_shape (
        .sending_i (q.state == ST_SEND),
        .bit_i     (q.frame[q.idx]),
        .cnt_i     (q.cnt),
        .t_zero_i  (q.t_zero),
        .t_one_i   (q.t_one),
        .invert_i  (q.bidir),
        .line_o    (line_nx)
    );

    assign per_last = q.period - CNT_W'(1);
    assign gap_last = (q.period << 1) + q.period - CNT_W'(1);

    always_comb begin
        d      = q;
        d.line = line_nx;
        unique case (q.state)
            ST_IDLE: begin
                d.bidir = bidir_i;
                if (req_valid_i) begin
                    d.state  = ST_SEND;
                    d.frame  = {req_value_i, req_telem_i, sum};
                    d.period = sel_period;
                    d.t_zero = sel_t0;
                    d.t_one  = sel_t1;
                    d.idx    = IDX_W'(FRAME_W - 1);
                    d.cnt    = '0;
                end
            end
            ST_SEND: begin
                if (q.cnt == per_last) begin
                    d.cnt = '0;
                    if (q.idx == '0) begin
                        d.state = ST_GAP;
                    end else begin
                        d.idx = q.idx - IDX_W'(1);
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (q.cnt == gap_last) begin
                    d.cnt   = '0;
                    d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = (q.state == ST_IDLE);
    assign busy_o      = (q.state != ST_IDLE);
    assign line_o      = q.line;

    // R4: the in-bit counter never reaches the period while sending
    a_r4_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_SEND) |-> (q.cnt < q.period));

    // R1: the bit pointer moves only at the end of a bit period
    a_r1_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_SEND && q.cnt != per_last) |=> $stable(q.idx));

    // R8: captured configuration holds while a frame is in flight
    a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state != ST_IDLE) |=> (q.state == ST_IDLE) ||
            ($stable(q.period) && $stable(q.bidir) && $stable(q.frame)));

    // R6: the line rests at its idle level during the gap
    a_r6_gap_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_GAP && $past(q.state) == ST_GAP) |-> (line_o == q.bidir));

    // R7: the gap always returns to idle before another frame
    a_r7_gap_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_GAP) |=> (q.state != ST_SEND));
endmodule

// File: tb/tb_dshot_tx.sv
module tb_dshot_tx;
    typedef struct {
        logic [15:0] frame;
        bit          bidir;
        int          per;
        longint      acc;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_value = '0;
    logic        req_telem = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic        bidir = 1'b0;
    logic        line;
    logic        busy;

    longint cyc = 0;
    int     vectors = 0;
    int     errs = 0;
    bit     mon_busy = 1'b0;
    bit     finished = 1'b0;
    item_t  sb [$];

    longint prev_acc = -1;
    int     prev_per = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dshot_tx #(
        .CYC_R150  (45),
        .CYC_R300  (36),
        .CYC_R600  (24),
        .CYC_R1200 (15)
    ) dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_value_i (req_value),
        .req_telem_i (req_telem),
        .rate_sel_i  (rate_sel),
        .bidir_i     (bidir),
        .line_o      (line),
        .busy_o      (busy)
    );

    function automatic int per_of(int r);
        case (r)
            0: return 45;
            1: return 36;
            2: return 24;
            default: return 15;
        endcase
    endfunction

    function automatic logic [3:0] exp_crc(logic [11:0] p, bit inv);
        logic [3:0] x;
        x = 4'((p ^ (p >> 4) ^ (p >> 8)) & 12'hF);
        return inv ? ~x : x;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    endtask

    // driver: offer one request, push the expected frame on acceptance
    task automatic send(logic [10:0] v, bit t, int r, bit b, bit held);
        item_t it;
        longint acc;
        req_value = v;
        req_telem = t;
        rate_sel  = 2'(r);
        bidir     = b;
        req_valid = 1'b1;
        forever begin
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        acc = cyc;
        req_valid = 1'b0;
        it.frame = {v, t, exp_crc({v, t}, b)};
        it.bidir = b;
        it.per   = per_of(r);
        it.acc   = acc;
        sb.push_back(it);
        chk(req_ready == 1'b0 && busy == 1'b1, "R7 busy after accept", {req_ready, busy}, 2'b01);
        if (held && prev_acc >= 0)
            chk(acc - prev_acc == longint'(19 * prev_per + 1), "R7 held accept spacing",
                acc - prev_acc, 19 * prev_per + 1);
        prev_acc = acc;
        prev_per = it.per;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: decode the line from pulse widths and compare
    initial begin
        forever begin
            item_t it;
            logic [15:0] got;
            longint st, prev_st;
            bit act;
            while (sb.size() == 0) @(negedge clk);
            it = sb.pop_front();
            mon_busy = 1'b1;
            act = ~it.bidir;
            got = '0;
            prev_st = 0;
            for (int k = 15; k >= 0; k--) begin
                int w;
                int ew;
                while (line != act) @(negedge clk);
                st = cyc;
                w = 0;
                while (line == act) begin
                    w++;
                    @(negedge clk);
                end
                got[k] = (2 * w > it.per);
                ew = it.frame[k] ? (2 * it.per + 1) / 3 : (it.per + 1) / 3;
                chk(w == ew, "R4 active width", w, ew);
                if (k == 15)
                    chk(st == it.acc + 1, "R4 first bit start", st, it.acc + 1);
                else
                    chk(st - prev_st == longint'(it.per), "R5 bit spacing", st - prev_st, it.per);
                prev_st = st;
            end
            chk(got[15:4] == it.frame[15:4], "R1 R10 value and telemetry fields", got[15:4], it.frame[15:4]);
            chk(got[3:0] == it.frame[3:0], it.bidir ? "R3 inverted checksum" : "R2 checksum",
                got[3:0], it.frame[3:0]);
            mon_busy = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        errs++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
        chk(busy == 1'b0, "R9 busy after reset", busy, 0);
        chk(line == 1'b0, "R9 line after reset", line, 0);

        // normal polarity, all rates, command and throttle edges, held requests
        send(11'd0,     1'b0, 3, 1'b0, 1'b0);
        send(11'd47,    1'b1, 2, 1'b0, 1'b1);
        send(11'd48,    1'b0, 1, 1'b0, 1'b1);
        send(11'd2047,  1'b1, 0, 1'b0, 1'b1);
        send(11'h555,   1'b0, 3, 1'b0, 1'b1);
        wait_idle();
        chk(line == 1'b0, "R6 idle low normal", line, 0);

        // bidirectional polarity
        bidir = 1'b1;
        repeat (3) @(negedge clk);
        chk(line == 1'b1, "R6 idle high bidir", line, 1);
        send(11'h2AA,   1'b1, 3, 1'b1, 1'b0);
        send(11'd1000,  1'b0, 2, 1'b1, 1'b1);
        send(11'd5,     1'b1, 1, 1'b1, 1'b1);
        wait_idle();

        // R8: configuration changed mid-frame must not affect it
        send(11'h123,   1'b1, 2, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        rate_sel = 2'd0;
        bidir    = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(line == 1'b0, "R6 idle follows bidir", line, 0);
        send(11'h7F0,   1'b0, 3, 1'b0, 1'b0);
        rate_sel = 2'd1;
        bidir    = 1'b1;
        wait_idle();
        bidir = 1'b0;

        while (sb.size() != 0 || mon_busy) @(negedge clk);
        repeat (5) @(negedge clk);
        summary();
    end
endmodule